// File: doc/BRIEF.md
# Energy Detect Power-Down Controller

This block decides when an Ethernet transceiver's data path may sleep, based on whether signal energy is present on the line. Three detector inputs report energy from 100BASE-TX signalling, 10BASE-T signalling and auto-negotiation link pulses. Any one of them raises the energy-present status at once. The status drops only after the line has been quiet for a programmable number of clock cycles, so the block does not chatter between states. While the mode is enabled and the status is low, the core is powered down and transmit is inhibited.

The detector logic, the interrupt logic and the configuration register stay clocked the whole time. When the mode is enabled, the block snapshots the data path's operating state as it enters power-down. On wake-up it hands that snapshot back with a one-cycle load strobe. It then holds transmit inhibited for a fixed settle window, during which the first packets may be lost. A rise of the energy status sets a sticky interrupt flag when the mask permits it. The active-low interrupt output reflects that flag until a management read-clear pulse arrives.

Top module: `energy_pd_ctrl`

## Requirements
- R1: While `ed_mode_en` is 0 and the block is awake, `core_pwrdn` stays 0. Once any wake settle window ends, `tx_inhibit` is also 0.
- R2: With `ed_mode_en` 1, `core_pwrdn` and `tx_inhibit` go to 1 one cycle after `energy_on` falls, and both stay there while `energy_on` is 0. `core_pwrdn` 1 always implies `tx_inhibit` 1.
- R3: Each of the three `energy_src` bits (bit 0: 100BASE-TX, bit 1: 10BASE-T, bit 2: auto-negotiation pulses) sets `energy_on` at the clock edge that samples it high.
- R4: `energy_on` clears at the edge that samples the `idle_limit`-th consecutive cycle with no energy. A value of 0 acts as 1. Any energy sample restarts the count.
- R5: One cycle after `energy_on` rises during power-down, `core_pwrdn` falls and `restore_load` pulses for exactly one cycle. During that pulse, `restore_state` equals the `run_state` value sampled when power-down began, whatever `run_state` did meanwhile.
- R6: After power-up, `tx_inhibit` stays 1 for WAKE_CYC cycles (counted from the `restore_load` cycle), then returns to 0.
- R7: When `irq_mask_en` is 1, `irq_n` goes to 0 at the same edge at which `energy_on` rises. When the mask is 0, a rise leaves `irq_n` at 1.
- R8: Once low, `irq_n` stays low until a cycle with `irq_clr` high. It returns to 1 at that edge, unless an `energy_on` rise with the mask set happens at the same edge, in which case it stays 0.
- R9: Clearing `ed_mode_en` during power-down wakes the core through the same restore pulse and settle window.
- R10: `cfg_q` resets to 0 and changes only at edges where `cfg_wr` is 1, including during power-down. Sleeping and waking leave it untouched.
- R11: After reset, `energy_on` is 0, `irq_n` is 1, `restore_load` is 0 and, with the mode disabled, `core_pwrdn` and `tx_inhibit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ed_mode_en | input | 1 | Enables energy-gated power-down |
| energy_src | input | 3 | Energy seen per signalling kind (100TX, 10T, auto-negotiation) |
| idle_limit | input | CNT_W | Quiet cycles before energy status clears |
| irq_mask_en | input | 1 | Allows the energy-rise interrupt |
| irq_clr | input | 1 | Management read-clear pulse for the interrupt flag |
| run_state | input | ST_W | Live operating state of the data path |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| energy_on | output | 1 | Energy-present status |
| core_pwrdn | output | 1 | Powers down the transceiver core |
| tx_inhibit | output | 1 | Blocks transmission |
| restore_load | output | 1 | One-cycle strobe to reload the saved state |
| restore_state | output | ST_W | Operating state saved at power-down entry |
| irq_n | output | 1 | Active-low interrupt |
| cfg_q | output | CFG_W | Configuration register contents |

## Verification
The main sleep and wake cycle is swept over every energy source, idle limits from 1 to 5 and both mask settings. This shows that each source alone wakes the core and that the quiet-time count is exact to the cycle for each limit. It also shows that the interrupt follows the mask alone. In the masked runs, a read-clear pulse coincides with the wake event, which shows that the rise takes priority over the clear. Separate patterns cover energy bursts that stop short of the limit (count restart rather than accumulation), a zero limit, a mode switch-off during sleep, and a configuration write made while the core sleeps.

// File: rtl/edpd_pkg.sv
// Shared types for the energy-detect power-down controller.
// Assumes: nothing beyond IEEE 1800-2017.
package edpd_pkg;
    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,   // core awake, data path usable
        PS_DOWN = 2'd1,   // core asleep, only detectors and management live
        PS_WAKE = 2'd2    // core awake, settling, transmit still blocked
    } pwr_state_t;

    localparam int unsigned NUM_SRC = 3;   // 100TX, 10T, auto-negotiation
endpackage

// File: rtl/edpd_energy_det.sv
// Energy status with quiet-time hysteresis.
// Sets the status as soon as any source reports energy; clears it after
// idle_limit consecutive quiet cycles (0 treated as 1).
// Assumes: energy_src already synchronous to clk.
module edpd_energy_det #(
    parameter int unsigned NSRC  = 3,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  energy_src,
    input  logic [CNT_W-1:0] idle_limit,
    output logic             energy_on,
    output logic             energy_rise
);
    logic             any_energy;
    logic [CNT_W-1:0] lim_eff;
    logic [CNT_W-1:0] quiet_cnt;
    logic             quiet_done;

    // Combine sources and derive the effective limit and expiry condition.
    always_comb begin
        any_energy  = |energy_src;
        lim_eff     = (idle_limit == '0) ? CNT_W'(1) : idle_limit;
        quiet_done  = ({1'b0, quiet_cnt} + (CNT_W+1)'(1)) >= {1'b0, lim_eff};
        energy_rise = any_energy & ~energy_on;
    end

    // Count consecutive quiet cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)               quiet_cnt <= '0;
        else if (any_energy)      quiet_cnt <= '0;
        else if (quiet_cnt != lim_eff) quiet_cnt <= quiet_cnt + CNT_W'(1);
    end

    // Energy status register: fast set, delayed clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          energy_on <= 1'b0;
        else if (any_energy) energy_on <= 1'b1;
        else if (quiet_done) energy_on <= 1'b0;
    end
endmodule

// File: rtl/edpd_pwr_fsm.sv
// Power sequencing: sleep when enabled and quiet, wake on energy or mode
// clear, restore the saved operating state, then block transmit for a
// settle window of WAKE_CYC cycles.
// Assumes: WAKE_CYC >= 1.
module edpd_pwr_fsm
    import edpd_pkg::*;
#(
    parameter int unsigned ST_W     = 4,
    parameter int unsigned WAKE_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ed_mode_en,
    input  logic            energy_on,
    input  logic [ST_W-1:0] run_state,
    output logic            core_pwrdn,
    output logic            tx_inhibit,
    output logic            restore_load,
    output logic [ST_W-1:0] restore_state
);
    localparam int unsigned WC_W = $clog2(WAKE_CYC + 1);

    pwr_state_t      state;
    logic [WC_W-1:0] wake_cnt;
    logic [ST_W-1:0] saved_q;

    // State transitions and settle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_RUN;
            wake_cnt <= '0;
        end else begin
            unique case (state)
                PS_RUN:  if (ed_mode_en && !energy_on) state <= PS_DOWN;
                PS_DOWN: if (!ed_mode_en || energy_on) begin
                    state    <= PS_WAKE;
                    wake_cnt <= '0;
                end
                PS_WAKE: begin
                    if (wake_cnt == WC_W'(WAKE_CYC - 1)) state <= PS_RUN;
                    wake_cnt <= wake_cnt + WC_W'(1);
                end
                default: state <= PS_RUN;
            endcase
        end
    end

    // Snapshot the live operating state on the way into power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) saved_q <= '0;
        else if (state == PS_RUN && ed_mode_en && !energy_on) saved_q <= run_state;
    end

    // Decode outputs from the state.
    always_comb begin
        core_pwrdn    = (state == PS_DOWN);
        tx_inhibit    = (state != PS_RUN);
        restore_load  = (state == PS_WAKE) && (wake_cnt == '0);
        restore_state = saved_q;
    end
endmodule

// File: rtl/edpd_irq.sv
// Sticky energy-rise interrupt flag with read-clear; a new event at the
// same edge as a clear keeps the flag set.
// Assumes: irq_clr is a single-cycle pulse from management.
module edpd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_evt,
    input  logic mask_en,
    input  logic irq_clr,
    output logic irq_n
);
    logic flag_q;

    // Set on an unmasked rise, clear on read-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (rise_evt && mask_en) flag_q <= 1'b1;
        else if (irq_clr)             flag_q <= 1'b0;
    end

    // Drive the active-low pin from the flag.
    always_comb irq_n = ~flag_q;
endmodule

// File: rtl/energy_pd_ctrl.sv
// Top of the energy-detect power-down controller. Holds the configuration
// register, which stays writable and unchanged across sleep and wake.
// Assumes: all inputs synchronous to clk; reset is synchronous active-low.
module energy_pd_ctrl #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned ST_W     = 4,
    parameter int unsigned CFG_W    = 8,
    parameter int unsigned WAKE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ed_mode_en,
    input  logic [2:0]       energy_src,
    input  logic [CNT_W-1:0] idle_limit,
    input  logic             irq_mask_en,
    input  logic             irq_clr,
    input  logic [ST_W-1:0]  run_state,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             energy_on,
    output logic             core_pwrdn,
    output logic             tx_inhibit,
    output logic             restore_load,
    output logic [ST_W-1:0]  restore_state,
    output logic             irq_n,
    output logic [CFG_W-1:0] cfg_q
);
    import edpd_pkg::*;

    logic rise_evt;

    edpd_energy_det #(.NSRC(NUM_SRC), .CNT_W(CNT_W)) u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .energy_src  (energy_src),
        .idle_limit  (idle_limit),
        .energy_on   (energy_on),
        .energy_rise (rise_evt)
    );

    edpd_pwr_fsm #(.ST_W(ST_W), .WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ed_mode_en    (ed_mode_en),
        .energy_on     (energy_on),
        .run_state     (run_state),
        .core_pwrdn    (core_pwrdn),
        .tx_inhibit    (tx_inhibit),
        .restore_load  (restore_load),
        .restore_state (restore_state)
    );

    edpd_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (rise_evt),
        .mask_en  (irq_mask_en),
        .irq_clr  (irq_clr),
        .irq_n    (irq_n)
    );

    // Configuration register: written only by management strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_wdata;
    end
endmodule

// File: rtl/energy_pd_ctrl_chk.sv
// Property checker for energy_pd_ctrl, attached by bind.
// Assumes: same parameters as the bound instance.
module energy_pd_ctrl_chk #(
    parameter int unsigned ST_W  = 4,
    parameter int unsigned CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ed_mode_en,
    input logic [2:0]       energy_src,
    input logic             irq_mask_en,
    input logic             irq_clr,
    input logic             cfg_wr,
    input logic             energy_on,
    input logic             core_pwrdn,
    input logic             tx_inhibit,
    input logic             restore_load,
    input logic             irq_n,
    input logic [CFG_W-1:0] cfg_q
);
    // R1
    mode_off_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ed_mode_en && !core_pwrdn) |=> !core_pwrdn);
    // R2
    pwrdn_blocks_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_pwrdn |-> tx_inhibit);
    // R3
    energy_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|energy_src) |=> energy_on);
    // R5
    wake_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_pwrdn) |-> restore_load);
    // R7
    masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !irq_mask_en) |=> irq_n);
    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !irq_clr) |=> !irq_n);
    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_q));
endmodule

bind energy_pd_ctrl energy_pd_ctrl_chk #(.ST_W(ST_W), .CFG_W(CFG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ed_mode_en   (ed_mode_en),
    .energy_src   (energy_src),
    .irq_mask_en  (irq_mask_en),
    .irq_clr      (irq_clr),
    .cfg_wr       (cfg_wr),
    .energy_on    (energy_on),
    .core_pwrdn   (core_pwrdn),
    .tx_inhibit   (tx_inhibit),
    .restore_load (restore_load),
    .irq_n        (irq_n),
    .cfg_q        (cfg_q)
);

// File: tb/energy_pd_ctrl_bench.sv
// Self-checking bench: sweeps sources, idle limits and mask settings.
module energy_pd_ctrl_bench;
    localparam int unsigned CNT_W = 8, ST_W = 4, CFG_W = 8, WAKE_CYC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ed_mode_en = 1'b0;
    logic [2:0] energy_src = '0;
    logic [CNT_W-1:0] idle_limit = '0;
    logic irq_mask_en = 1'b0, irq_clr = 1'b0, cfg_wr = 1'b0;
    logic [ST_W-1:0] run_state = '0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic energy_on, core_pwrdn, tx_inhibit, restore_load, irq_n;
    logic [ST_W-1:0] restore_state;
    logic [CFG_W-1:0] cfg_q;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    energy_pd_ctrl #(.CNT_W(CNT_W), .ST_W(ST_W), .CFG_W(CFG_W), .WAKE_CYC(WAKE_CYC))
    u_energy_pd_ctrl (
        .clk(clk), .rst_n(rst_n), .ed_mode_en(ed_mode_en), .energy_src(energy_src),
        .idle_limit(idle_limit), .irq_mask_en(irq_mask_en), .irq_clr(irq_clr),
        .run_state(run_state), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .energy_on(energy_on), .core_pwrdn(core_pwrdn), .tx_inhibit(tx_inhibit),
        .restore_load(restore_load), .restore_state(restore_state),
        .irq_n(irq_n), .cfg_q(cfg_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [ST_W-1:0] sv;
        step(3);
        // R11 reset state
        chk("R11 energy_on", energy_on, 0);
        chk("R11 irq_n", irq_n, 1);
        chk("R11 core_pwrdn", core_pwrdn, 0);
        chk("R11 tx_inhibit", tx_inhibit, 0);
        chk("R11 restore_load", restore_load, 0);
        chk("R10 cfg reset", cfg_q, 0);
        rst_n = 1'b1;
        step(1);

        // R1: mode disabled, quiet line, never sleeps
        for (int i = 0; i < 20; i++) begin
            chk("R1 core_pwrdn", core_pwrdn, 0);
            chk("R1 tx_inhibit", tx_inhibit, 0);
            step(1);
        end

        cfg_wr = 1'b1; cfg_wdata = 8'hA5;
        step(1);
        cfg_wr = 1'b0;

        // Bring energy up, clear any flag
        energy_src = 3'b001;
        step(2);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        step(WAKE_CYC + 2);

        // Main sweep: source x idle limit x mask
        for (int s = 0; s < 3; s++) begin
            for (int lim = 1; lim <= 5; lim++) begin
                for (int m = 0; m < 2; m++) begin
                    sv = ST_W'(s * 5 + lim + m * 7);
                    ed_mode_en  = 1'b1;
                    idle_limit  = CNT_W'(lim);
                    irq_mask_en = m[0];
                    run_state   = sv;
                    energy_src  = 3'b000;
                    for (int k = 1; k < lim; k++) begin
                        step(1);
                        chk("R4 still on", energy_on, 1);
                    end
                    step(1);
                    chk("R4 cleared at limit", energy_on, 0);
                    chk("R2 not yet down", core_pwrdn, 0);
                    step(1);
                    chk("R2 core_pwrdn", core_pwrdn, 1);
                    chk("R2 tx_inhibit", tx_inhibit, 1);
                    run_state = ~sv;
                    if (s == 1 && lim == 3) begin
                        cfg_wr = 1'b1; cfg_wdata = 8'h3C;   // write while asleep
                    end
                    step(1);
                    cfg_wr = 1'b0;
                    step(2);
                    chk("R2 stays down", core_pwrdn, 1);
                    chk("R10 cfg kept", cfg_q, (s > 1 || (s == 1 && lim >= 3)) ? 8'h3C : 8'hA5);
                    // Wake via one source; in masked runs clear coincides
                    energy_src = 3'b001 << s;
                    irq_clr = m[0];
                    step(1);
                    irq_clr = 1'b0;
                    chk("R3 energy_on", energy_on, 1);
                    chk("R7/R8 irq_n on rise", irq_n, m[0] ? 0 : 1);
                    chk("R5 still down", core_pwrdn, 1);
                    step(1);
                    chk("R5 core up", core_pwrdn, 0);
                    chk("R5 restore_load", restore_load, 1);
                    chk("R5 restore_state", restore_state, sv);
                    chk("R6 tx blocked", tx_inhibit, 1);
                    step(1);
                    chk("R5 single pulse", restore_load, 0);
                    step(WAKE_CYC - 2);
                    chk("R6 last settle cycle", tx_inhibit, 1);
                    step(1);
                    chk("R6 tx released", tx_inhibit, 0);
                    chk("R10 cfg after wake", cfg_q, (s > 1 || (s == 1 && lim >= 3)) ? 8'h3C : 8'hA5);
                    chk("R8 sticky", irq_n, m[0] ? 0 : 1);
                    irq_clr = 1'b1;
                    step(1);
                    irq_clr = 1'b0;
                    chk("R8 cleared", irq_n, 1);
                end
            end
        end

        // R4: bursts shorter than the limit restart the count
        idle_limit = 8'd4;
        irq_mask_en = 1'b0;
        energy_src = 3'b000;
        step(3);
        chk("R4 before burst", energy_on, 1);
        energy_src = 3'b010;
        step(1);
        energy_src = 3'b000;
        step(3);
        chk("R4 restarted count", energy_on, 1);
        chk("R4 no sleep", core_pwrdn, 0);
        step(1);
        chk("R4 fourth quiet", energy_on, 0);
        energy_src = 3'b100;
        step(2);
        step(WAKE_CYC + 1);

        // R4: limit 0 acts as 1
        idle_limit = 8'd0;
        energy_src = 3'b000;
        step(1);
        chk("R4 zero limit", energy_on, 0);
        step(1);
        chk("R2 down after zero limit", core_pwrdn, 1);

        // R9: mode clear during sleep wakes with restore
        ed_mode_en = 1'b0;
        step(1);
        chk("R9 core up", core_pwrdn, 0);
        chk("R9 restore_load", restore_load, 1);
        chk("R9 tx blocked", tx_inhibit, 1);
        step(WAKE_CYC);
        chk("R9 tx released", tx_inhibit, 0);
        for (int i = 0; i < 10; i++) begin
            step(1);
            chk("R1 stays awake quiet", core_pwrdn, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule